// File: doc/BRIEF.md
# Lockable Watchdog Timer with Interrupt and Reset Outputs

This block is a watchdog timer on a simple word-addressed register bus with 32-bit data. A down-counter starts from a programmable reload value. Each time it reaches zero it raises an interrupt flag and starts again from the reload value. If the flag is still set at the next zero and the reset output is enabled, a sticky reset request asserts. Software services the watchdog by writing the interrupt-clear register. That write drops the flag and restarts the count.

A key-protected lock guards every other register against stray writes. A test mode lets software drive both outputs directly. Eight read-only identification bytes let software recognise the block. Reads are combinational from the addressed register. Writes take effect at the clock edge that samples them.

Top module: `wdt_lockable`

## Requirements
- R1: After reset, reload (index 0) and count (index 1) read 0xFFFFFFFF, control (index 2) reads 0, lock (index 6) reads 0, test control (index 7) and test output (index 8) read 0, and both outputs are low.
- R2: While control bit 0 is set, the count falls by one per cycle. While it is clear, the count holds. A write to the reload register (index 0) sets both the reload value and the count to the written value.
- R3: When the count is zero and counting is enabled, the next cycle sets the raw interrupt flag and reloads the count. For a reload value L, the flag is therefore seen L+1 cycles after the reload write.
- R4: Raw status (index 4) reads the raw flag in bit 0. Masked status (index 5) and `wd_irq` (outside test mode) equal the raw flag ANDed with control bit 0.
- R5: Any write to the interrupt-clear register (index 3) clears the raw flag and reloads the count from the reload value.
- R6: If the count reaches zero while the raw flag is set and control bit 1 is set, `wd_rst` asserts one cycle later and stays asserted until block reset. With control bit 1 clear, it never asserts.
- R7: Writing 0x1ACCE551 to the lock register (index 6) allows writes. Any other value blocks them. Lock bit 0 reads 1 when blocked and 0 when allowed.
- R8: While writes are blocked, writes to every register other than the lock register have no effect, including interrupt clear.
- R9: With test control bit 0 (index 7) set, test output bit 0 (index 8) drives `wd_irq` and bit 1 drives `wd_rst`. With it clear, the outputs follow R4 and R6.
- R10: Indices 9 to 16 read the fixed bytes 0x05, 0x18, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order, with the upper 24 bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_en | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the addressed register |
| wd_irq | output | 1 | Interrupt output |
| wd_rst | output | 1 | Reset request output |

## Verification
Register writes show at the read port and the outputs one edge after the write is sampled. Read data is valid in the same cycle as the address, so the bench drives on the falling edge and samples a nanosecond later.

After a reload write of L, the count is L, then falls by one per edge. The raw flag, masked status and `wd_irq` rise exactly L+1 edges after the write. With reset enabled, `wd_rst` rises 2L+2 edges after the write. The bench counts falling edges from the write and checks the value just before and just at each of these edges.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int          DATA_W     = 32;
  localparam logic [31:0] UNLOCK_KEY = 32'h1ACCE551;
  localparam int          IX_LOAD    = 0;
  localparam int          IX_COUNT   = 1;
  localparam int          IX_CTRL    = 2;
  localparam int          IX_ICLR    = 3;
  localparam int          IX_RAW     = 4;
  localparam int          IX_MASKED  = 5;
  localparam int          IX_LOCK    = 6;
  localparam int          IX_TCTRL   = 7;
  localparam int          IX_TOUT    = 8;
  localparam int          IX_ID_BASE = 9;
  localparam int          ID_COUNT   = 8;

  function automatic logic [7:0] id_byte(input int k);
    case (k)
      0: id_byte = 8'h05;
      1: id_byte = 8'h18;
      2: id_byte = 8'h04;
      3: id_byte = 8'h00;
      4: id_byte = 8'h0D;
      5: id_byte = 8'hF0;
      6: id_byte = 8'h05;
      7: id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
  import wdt_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] load_q,
  output logic [1:0]    ctrl_q,
  output logic          locked_q,
  output logic          tmode_q,
  output logic [1:0]    tout_q,
  output logic          restart,
  output logic [DW-1:0] restart_val,
  output logic          clr_irq
);
  logic          wr_any, wr_ok;
  logic [DW-1:0] load_nx;
  logic [1:0]    ctrl_nx, tout_nx;
  logic          locked_nx, tmode_nx;

  function automatic logic hit(input logic [AW-1:0] a, input int ix);
    hit = (a == AW'(ix));
  endfunction

  assign wr_any = bus_en & bus_wr;
  assign wr_ok  = wr_any & ~locked_q;

  always_comb begin
    load_nx   = load_q;
    ctrl_nx   = ctrl_q;
    tmode_nx  = tmode_q;
    tout_nx   = tout_q;
    locked_nx = locked_q;
    if (wr_ok && hit(bus_addr, IX_LOAD))  load_nx  = bus_wdata;
    if (wr_ok && hit(bus_addr, IX_CTRL))  ctrl_nx  = bus_wdata[1:0];
    if (wr_ok && hit(bus_addr, IX_TCTRL)) tmode_nx = bus_wdata[0];
    if (wr_ok && hit(bus_addr, IX_TOUT))  tout_nx  = bus_wdata[1:0];
    if (wr_any && hit(bus_addr, IX_LOCK)) locked_nx = (bus_wdata != UNLOCK_KEY);
  end

  assign clr_irq     = wr_ok & hit(bus_addr, IX_ICLR);
  assign restart     = wr_ok & (hit(bus_addr, IX_LOAD) | hit(bus_addr, IX_ICLR));
  assign restart_val = hit(bus_addr, IX_LOAD) ? bus_wdata : load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q   <= '1;
      ctrl_q   <= '0;
      locked_q <= 1'b0;
      tmode_q  <= 1'b0;
      tout_q   <= '0;
    end else begin
      load_q   <= load_nx;
      ctrl_q   <= ctrl_nx;
      locked_q <= locked_nx;
      tmode_q  <= tmode_nx;
      tout_q   <= tout_nx;
    end
  end

  AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && bus_en && bus_wr && bus_addr != AW'(IX_LOCK)) |=>
      ($stable(load_q) && $stable(ctrl_q) && $stable(tmode_q) && $stable(tout_q))); // R8
  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_wr && bus_addr == AW'(IX_LOCK) && bus_wdata == UNLOCK_KEY) |=> !locked_q); // R7
endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          rst_en,
  input  logic [DW-1:0] load_val,
  input  logic          restart,
  input  logic [DW-1:0] restart_val,
  input  logic          clr_irq,
  output logic [DW-1:0] count_q,
  output logic          raw_q,
  output logic          rst_q
);
  logic [DW-1:0] count_nx;
  logic          raw_nx, rst_nx, at_zero;

  assign at_zero = (count_q == '0);

  always_comb begin
    count_nx = count_q;
    raw_nx   = raw_q;
    rst_nx   = rst_q;
    if (restart) begin
      count_nx = restart_val;
    end else if (cnt_en) begin
      if (at_zero) begin
        count_nx = load_val;
        raw_nx   = 1'b1;
        if (raw_q && rst_en) rst_nx = 1'b1;
      end else begin
        count_nx = count_q - 1'b1;
      end
    end
    if (clr_irq) raw_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '1;
      raw_q   <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      count_q <= count_nx;
      raw_q   <= raw_nx;
      rst_q   <= rst_nx;
    end
  end

  AST_ZERO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && at_zero && !restart && !clr_irq) |=> raw_q); // R3
  AST_ZERO_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && at_zero && !restart) |=> (count_q == $past(load_val))); // R3
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_irq |=> !raw_q); // R5
  AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> rst_q); // R6
endmodule

// File: rtl/wdt_rd_mux.sv
module wdt_rd_mux
  import wdt_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] load_q,
  input  logic [DW-1:0] count_q,
  input  logic [1:0]    ctrl_q,
  input  logic          raw_q,
  input  logic          locked_q,
  input  logic          tmode_q,
  input  logic [1:0]    tout_q,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] id_word [ID_COUNT];

  for (genvar g = 0; g < ID_COUNT; g++) begin : g_id
    assign id_word[g] = DW'(id_byte(g));
  end

  always_comb begin
    rdata = '0;
    case (int'(addr))
      IX_LOAD:   rdata = load_q;
      IX_COUNT:  rdata = count_q;
      IX_CTRL:   rdata = DW'(ctrl_q);
      IX_RAW:    rdata = DW'(raw_q);
      IX_MASKED: rdata = DW'(raw_q & ctrl_q[0]);
      IX_LOCK:   rdata = DW'(locked_q);
      IX_TCTRL:  rdata = DW'(tmode_q);
      IX_TOUT:   rdata = DW'(tout_q);
      default: begin
        for (int k = 0; k < ID_COUNT; k++)
          if (int'(addr) == IX_ID_BASE + k) rdata = id_word[k];
      end
    endcase
  end
endmodule

// File: rtl/wdt_lockable.sv
module wdt_lockable
  import wdt_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          wd_irq,
  output logic          wd_rst
);
  logic [DW-1:0] load_q, restart_val, count_q;
  logic [1:0]    ctrl_q, tout_q;
  logic          locked_q, tmode_q, restart, clr_irq, raw_q, rst_q;

  wdt_ctrl_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .load_q(load_q),
    .ctrl_q(ctrl_q), .locked_q(locked_q), .tmode_q(tmode_q), .tout_q(tout_q),
    .restart(restart), .restart_val(restart_val), .clr_irq(clr_irq)
  );

  wdt_downcount #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_en(ctrl_q[0]), .rst_en(ctrl_q[1]),
    .load_val(load_q), .restart(restart), .restart_val(restart_val),
    .clr_irq(clr_irq), .count_q(count_q), .raw_q(raw_q), .rst_q(rst_q)
  );

  wdt_rd_mux #(.DW(DW), .AW(AW)) u_rd (
    .addr(bus_addr), .load_q(load_q), .count_q(count_q), .ctrl_q(ctrl_q),
    .raw_q(raw_q), .locked_q(locked_q), .tmode_q(tmode_q), .tout_q(tout_q),
    .rdata(bus_rdata)
  );

  assign wd_irq = tmode_q ? tout_q[0] : (raw_q & ctrl_q[0]);
  assign wd_rst = tmode_q ? tout_q[1] : rst_q;
endmodule

// File: tb/tb_wdt_lockable.sv
module tb_wdt_lockable;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        wd_irq, wd_rst;
  int          n_chk = 0, n_bad = 0;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  always #2.5 clk = ~clk;

  wdt_lockable dut (.clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wd_irq(wd_irq), .wd_rst(wd_rst));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = 5'(a);
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic rchk(input string req, input int a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [7:0] exp_id(input int k);
    logic [63:0] t = 64'h05_18_04_00_0D_F0_05_B1;
    return t[63-8*k -: 8];
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] d0, d1;
    do_reset();
    // R1 reset state
    rchk("R1 load", 0, 32'hFFFF_FFFF);
    rchk("R1 count", 1, 32'hFFFF_FFFF);
    rchk("R1 ctrl", 2, 0);
    rchk("R1 lock", 6, 0);
    rchk("R1 tctrl", 7, 0);
    rchk("R1 tout", 8, 0);
    chk("R1 irq", 32'(wd_irq), 0);
    chk("R1 rst", 32'(wd_rst), 0);
    // R2 disabled counter holds
    repeat (3) @(negedge clk);
    rchk("R2 hold", 1, 32'hFFFF_FFFF);
    // R10 identification bytes
    for (int k = 0; k < 8; k++) rchk("R10 id", 9 + k, 32'(exp_id(k)));

    // R2 R3 R4 R5 period sweep
    wr(2, 1);
    for (int L = 1; L <= 6; L++) begin
      wr(0, L);
      rchk("R2 restart", 1, L);
      for (int k = 1; k <= L; k++) begin
        @(negedge clk);
        rchk("R2 decrement", 1, L - k);
        chk("R3 early irq", 32'(wd_irq), 0);
      end
      @(negedge clk);
      rchk("R3 raw set", 4, 1);
      rchk("R4 masked", 5, 1);
      chk("R4 irq", 32'(wd_irq), 1);
      rchk("R3 reload", 1, L);
      wr(3, 32'hDEAD);
      rchk("R5 clear raw", 4, 0);
      rchk("R5 reload", 1, L);
      chk("R5 irq low", 32'(wd_irq), 0);
    end
    // R4 mask with counting off
    wr(0, 2);
    repeat (3) @(negedge clk);
    wr(2, 0);
    rchk("R4 raw kept", 4, 1);
    rchk("R4 masked off", 5, 0);
    chk("R4 irq off", 32'(wd_irq), 0);
    rd(1, d0); @(negedge clk); rd(1, d1);
    chk("R2 frozen", d1, d0);
    wr(3, 0);

    // R6 reset disabled
    wr(2, 1);
    wr(0, 3);
    repeat (10) @(negedge clk);
    chk("R6 no rst when disabled", 32'(wd_rst), 0);
    wr(3, 0);
    wr(2, 3);
    wr(0, 3);
    repeat (7) @(negedge clk);
    chk("R6 not yet", 32'(wd_rst), 0);
    rchk("R6 raw pending", 4, 1);
    @(negedge clk);
    chk("R6 rst asserted", 32'(wd_rst), 1);
    wr(3, 0);
    repeat (5) @(negedge clk);
    chk("R6 sticky", 32'(wd_rst), 1);
    do_reset();
    chk("R1 rst cleared", 32'(wd_rst), 0);

    // R7 R8 lock
    wr(6, 32'h1234_5678);
    rchk("R7 locked", 6, 1);
    wr(0, 5);   rchk("R8 load kept", 0, 32'hFFFF_FFFF);
    wr(2, 3);   rchk("R8 ctrl kept", 2, 0);
    wr(7, 1);   rchk("R8 tctrl kept", 7, 0);
    wr(8, 3);   rchk("R8 tout kept", 8, 0);
    chk("R8 outputs", {30'b0, wd_rst, wd_irq}, 0);
    for (int b = 0; b < 32; b++) begin
      wr(6, KEY ^ (32'h1 << b));
      rchk("R7 near key", 6, 1);
    end
    wr(6, KEY);
    rchk("R7 unlocked", 6, 0);
    wr(0, 7); rchk("R7 write ok", 0, 7);
    wr(0, 2); wr(2, 1);
    repeat (3) @(negedge clk);
    rchk("R8 raw pending", 4, 1);
    wr(6, 0);
    wr(3, 0);
    rchk("R8 clear ignored", 4, 1);
    wr(6, KEY);
    wr(3, 0);
    rchk("R5 clear after unlock", 4, 0);

    // R9 test mode
    wr(2, 0);
    wr(7, 1);
    for (int v = 0; v < 4; v++) begin
      wr(8, v);
      rchk("R9 tout read", 8, v);
      chk("R9 irq", 32'(wd_irq), v & 1);
      chk("R9 rst", 32'(wd_rst), (v >> 1) & 1);
    end
    wr(7, 0);
    chk("R9 irq released", 32'(wd_irq), 0);
    chk("R9 rst released", 32'(wd_rst), 0);

    finish_run();
  end
endmodule